// File: doc/BRIEF.md
# Charge Permission and Dead-Battery Timer

This block turns a finished charger classification into the three status signals a system uses to decide whether it may charge, how hard it may charge, and whether the USB data lines are connected. The upstream detector reports a 3-bit port kind with a one-cycle done strobe. The block registers the result into three outputs. The charge-allowed indicator is an active-low open-drain pin, so it is modelled as a pull-low enable. The charger-found flag is push-pull. The switch-closed indicator is also open-drain, and a matching data-switch enable drives the analog switch. The data switch closes only for ports that carry data, and only while the battery input reports a good battery.

When a charger is present and the battery input is low, a dead-battery timer counts slow ticks. The battery may recover before the count runs out. In that case the timer clears and nothing else changes. If the battery stays low for the full interval, the block enters a lockout: charge permission is withdrawn, the charger flag drops and the switch stays open. The lockout lasts until the battery input rises. That rising edge produces a one-cycle request to the detector to run classification again, and the block then waits for a fresh done strobe.

The state machine has four states. ST_WAIT holds quiet outputs until a result arrives. ST_HOLD holds a classification. ST_DBP holds a classification while the timer runs. ST_LOCKOUT is the expired condition. The transitions are:
- accept: ST_WAIT to ST_HOLD or ST_DBP on done.
- reclassify: ST_HOLD or ST_DBP on done.
- arm: ST_HOLD to ST_DBP when a charger is held and the battery is low.
- recover: ST_DBP to ST_HOLD when the battery goes high.
- expire: ST_DBP to ST_LOCKOUT on the final tick.
- restart: ST_LOCKOUT to ST_WAIT on a battery rising edge.
- drop: any state to ST_WAIT when VBUS is not valid.

Top module: `charge_perm_ctl`

## Requirements
- R1: While vbus_ok is low, and out of reset, chg_ok_oe, chg_found, sw_close_oe and data_sw_en are all 0 one clock later. A loss of vbus_ok clears a held result.
- R2: Port kind 1 (standard data port) gives chg_ok_oe=1 and chg_found=0. sw_close_oe=1 only if batt_good was 1 when done was seen, otherwise 0.
- R3: Port kind 2 (charging data port) gives chg_ok_oe=1 and chg_found=1. sw_close_oe equals batt_good at done.
- R4: Port kinds 3 (dedicated charger), 4 (divider charger A) and 5 (divider charger B) give chg_ok_oe=1, chg_found=1 and sw_close_oe=0 for either battery level.
- R5: Port kinds 6 (pulled-up lines) and 7 (open lines) give chg_ok_oe=1, chg_found=0 and sw_close_oe=0. Kind 0 (no charger) gives all three 0.
- R6: Outputs are registered and change only on a done strobe, on timer expiry, or on loss of vbus_ok. A change in batt_good alone leaves them as they are.
- R7: With a charger held (kinds 1 to 7) and batt_good low, the DBP_TICKS-th slow_tick seen while low clears chg_ok_oe, chg_found and sw_close_oe at that clock edge.
- R8: If batt_good goes high before expiry, the count clears without effect on the outputs. After batt_good falls again, a full DBP_TICKS ticks are needed to expire.
- R9: In lockout a done strobe is ignored. A rising batt_good gives redetect_req=1 for exactly one cycle, and the next done strobe is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_ok | input | 1 | VBUS above the valid threshold |
| class_done | input | 1 | One-cycle strobe: port_kind is final |
| port_kind | input | 3 | Classification code, 0 to 7 as in R2 to R5 |
| batt_good | input | 1 | High when the battery is good, low when it is dead |
| slow_tick | input | 1 | One-cycle pulse that times the dead-battery interval |
| chg_ok_oe | output | 1 | Pull the charge-allowed pin low (charging permitted) |
| chg_found | output | 1 | Charger-detected flag (high-current charging allowed) |
| sw_close_oe | output | 1 | Pull the switch-status pin low (switch closed) |
| data_sw_en | output | 1 | Enable for the analog data switch |
| redetect_req | output | 1 | One-cycle request to rerun charger detection |

## Verification
The bench builds the block with DBP_TICKS set to 5 instead of the default of about half an hour of one-second ticks. With that setting, expiry, an interrupted count, and the restart after lockout can all be reached in a few dozen cycles, while the same comparison logic is still used. Ticks are issued one at a time, so the bench can check that the fourth tick after a cleared count leaves charging allowed and that the fifth tick withdraws it.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    typedef enum logic [2:0] {
        PK_NONE   = 3'd0,
        PK_SDP    = 3'd1,
        PK_CDP    = 3'd2,
        PK_DCP    = 3'd3,
        PK_DIV_A  = 3'd4,
        PK_DIV_B  = 3'd5,
        PK_PULLUP = 3'd6,
        PK_OPEN   = 3'd7
    } port_kind_e;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_HOLD,
        ST_DBP,
        ST_LOCKOUT
    } cpm_state_e;

    typedef struct packed {
        logic allow;
        logic found;
        logic close;
    } cpm_out_t;

endpackage

// File: rtl/cpm_decode.sv
module cpm_decode
    import cpm_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       batt,
    output cpm_out_t   res,
    output logic       is_chg
);
    always_comb begin
        res    = '0;
        is_chg = 1'b1;
        unique case (port_kind_e'(kind))
            PK_NONE:   is_chg = 1'b0;
            PK_SDP:    res = '{allow: 1'b1, found: 1'b0, close: batt};
            PK_CDP:    res = '{allow: 1'b1, found: 1'b1, close: batt};
            PK_DCP,
            PK_DIV_A,
            PK_DIV_B:  res = '{allow: 1'b1, found: 1'b1, close: 1'b0};
            PK_PULLUP,
            PK_OPEN:   res = '{allow: 1'b1, found: 1'b0, close: 1'b0};
            default:   is_chg = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpm_dbp_timer.sv
module cpm_dbp_timer #(
    parameter int unsigned LIMIT = 1920
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cpm_rise.sv
module cpm_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= 1'b1;
        else        d_q <= d;
    end

    assign rise = d && !d_q;
endmodule

// File: rtl/charge_perm_ctl.sv
module charge_perm_ctl
    import cpm_pkg::*;
#(
    parameter int unsigned DBP_TICKS = 1920
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbus_ok,
    input  logic       class_done,
    input  logic [2:0] port_kind,
    input  logic       batt_good,
    input  logic       slow_tick,
    output logic       chg_ok_oe,
    output logic       chg_found,
    output logic       sw_close_oe,
    output logic       data_sw_en,
    output logic       redetect_req
);
    cpm_state_e state_q, state_d;
    cpm_out_t   out_q, dec_res;
    logic       dec_chg, has_chg_q, expire, batt_rise, redet_q;

    cpm_decode u_dec (
        .kind   (port_kind),
        .batt   (batt_good),
        .res    (dec_res),
        .is_chg (dec_chg)
    );

    cpm_dbp_timer #(.LIMIT(DBP_TICKS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_DBP),
        .clr    (class_done),
        .tick   (slow_tick),
        .expire (expire)
    );

    cpm_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (batt_good),
        .rise  (batt_rise)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!vbus_ok) begin
            state_d = ST_WAIT;                              // drop
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (class_done)                          // accept
                        state_d = (dec_chg && !batt_good) ? ST_DBP : ST_HOLD;
                end
                ST_HOLD: begin
                    if (class_done)                          // reclassify
                        state_d = (dec_chg && !batt_good) ? ST_DBP : ST_HOLD;
                    else if (has_chg_q && !batt_good)        // arm
                        state_d = ST_DBP;
                end
                ST_DBP: begin
                    if (class_done)                          // reclassify
                        state_d = (dec_chg && !batt_good) ? ST_DBP : ST_HOLD;
                    else if (batt_good)                      // recover
                        state_d = ST_HOLD;
                    else if (expire)                         // expire
                        state_d = ST_LOCKOUT;
                end
                ST_LOCKOUT: begin
                    if (batt_rise)                           // restart
                        state_d = ST_WAIT;
                end
                default: state_d = ST_WAIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= '0;
            has_chg_q <= 1'b0;
            redet_q   <= 1'b0;
        end else begin
            redet_q <= vbus_ok && (state_q == ST_LOCKOUT) && batt_rise;
            if (!vbus_ok) begin
                out_q     <= '0;
                has_chg_q <= 1'b0;
            end else if (class_done && state_q != ST_LOCKOUT) begin
                out_q     <= dec_res;
                has_chg_q <= dec_chg;
            end else if (state_q == ST_DBP && !batt_good && expire) begin
                out_q     <= '0;
                has_chg_q <= 1'b0;
            end
        end
    end

    assign chg_ok_oe    = out_q.allow;
    assign chg_found    = out_q.found;
    assign sw_close_oe  = out_q.close;
    assign data_sw_en   = out_q.close;
    assign redetect_req = redet_q;

endmodule

// File: rtl/cpm_checker.sv
module cpm_checker (
    input logic clk,
    input logic rst_n,
    input logic vbus_ok,
    input logic class_done,
    input logic batt_good,
    input logic chg_ok_oe,
    input logic chg_found,
    input logic sw_close_oe,
    input logic redetect_req
);
    a_r1_no_vbus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !vbus_ok |=> (!chg_ok_oe && !chg_found && !sw_close_oe));

    a_r2_close_needs_good_batt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_close_oe) |-> ($past(class_done) && $past(batt_good)));

    a_r3_closed_implies_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        sw_close_oe |-> chg_ok_oe);

    a_r6_allow_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_ok_oe) |-> $past(class_done));

    a_r6_found_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_found) |-> $past(class_done));

    a_r7_allow_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chg_ok_oe) |-> ($past(!vbus_ok) || $past(class_done) || !$past(batt_good)));

    a_r9_redetect_single: assert property (@(posedge clk) disable iff (!rst_n)
        redetect_req |=> !redetect_req);

    a_r9_redetect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        redetect_req |-> (!chg_ok_oe && !chg_found && !sw_close_oe && $past(batt_good)));
endmodule

bind charge_perm_ctl cpm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vbus_ok      (vbus_ok),
    .class_done   (class_done),
    .batt_good    (batt_good),
    .chg_ok_oe    (chg_ok_oe),
    .chg_found    (chg_found),
    .sw_close_oe  (sw_close_oe),
    .redetect_req (redetect_req)
);

// File: tb/tb_charge_perm_ctl.sv
module tb_charge_perm_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vbus_ok = 1'b0;
    logic       class_done = 1'b0;
    logic [2:0] port_kind = 3'd0;
    logic       batt_good = 1'b1;
    logic       slow_tick = 1'b0;
    logic       chg_ok_oe, chg_found, sw_close_oe, data_sw_en, redetect_req;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    charge_perm_ctl #(.DBP_TICKS(5)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .vbus_ok      (vbus_ok),
        .class_done   (class_done),
        .port_kind    (port_kind),
        .batt_good    (batt_good),
        .slow_tick    (slow_tick),
        .chg_ok_oe    (chg_ok_oe),
        .chg_found    (chg_found),
        .sw_close_oe  (sw_close_oe),
        .data_sw_en   (data_sw_en),
        .redetect_req (redetect_req)
    );

    // {kind, batt, allow, found, close}
    localparam logic [6:0] VEC [16] = '{
        {3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd1, 1'b1, 1'b1, 1'b0, 1'b1},
        {3'd1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd2, 1'b1, 1'b1, 1'b1, 1'b1},
        {3'd2, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd4, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd4, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd5, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd5, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd6, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd6, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd7, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd7, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // {allow, found, close, data_sw_en}
    function automatic logic [3:0] outs();
        return {chg_ok_oe, chg_found, sw_close_oe, data_sw_en};
    endfunction

    task automatic pulse_done(input logic [2:0] k, input logic b);
        @(negedge clk);
        port_kind  = k;
        batt_good  = b;
        class_done = 1'b1;
        @(negedge clk);
        class_done = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4, 3'd5: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        check("R1", "reset outputs", outs(), 4'b0000);
        check("R1", "reset redetect", {3'b0, redetect_req}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R1: done while vbus not valid is ignored
        pulse_done(3'd3, 1'b1);
        check("R1", "done without vbus", outs(), 4'b0000);
        vbus_ok = 1'b1;
        idle(1);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < 16; i++) begin
            pulse_done(VEC[i][6:4], VEC[i][3]);
            check(tag_of(VEC[i][6:4]), $sformatf("kind %0d batt %0d", VEC[i][6:4], VEC[i][3]),
                  outs(), {VEC[i][2:0], VEC[i][0]});
        end

        // R6: battery drop alone does not move outputs
        pulse_done(3'd1, 1'b1);
        check("R6", "standard port closed", outs(), 4'b1011);
        @(negedge clk);
        batt_good = 1'b0;
        idle(3);
        check("R6", "after battery drop", outs(), 4'b1011);
        batt_good = 1'b1;
        idle(2);

        // R1: loss of vbus clears held result
        vbus_ok = 1'b0;
        idle(1);
        check("R1", "vbus loss", outs(), 4'b0000);
        vbus_ok = 1'b1;
        idle(2);
        check("R1", "vbus back without done", outs(), 4'b0000);

        // R8: interrupted count
        pulse_done(3'd3, 1'b0);
        ticks(3);
        check("R8", "three ticks", outs(), 4'b1100);
        @(negedge clk);
        batt_good = 1'b1;
        idle(2);
        batt_good = 1'b0;
        idle(2);
        ticks(4);
        check("R8", "four ticks after clear", outs(), 4'b1100);
        // R7: fifth tick expires
        ticks(1);
        check("R7", "expiry", outs(), 4'b0000);

        // R9: lockout ignores done, restart on rising battery
        pulse_done(3'd2, 1'b0);
        check("R9", "done in lockout", outs(), 4'b0000);
        check("R9", "no redetect yet", {3'b0, redetect_req}, 4'b0000);
        batt_good = 1'b1;
        @(negedge clk);
        check("R9", "redetect pulse", {3'b0, redetect_req}, 4'b0001);
        @(negedge clk);
        check("R9", "redetect ends", {3'b0, redetect_req}, 4'b0000);
        check("R9", "quiet after restart", outs(), 4'b0000);
        pulse_done(3'd2, 1'b1);
        check("R9", "new done accepted", outs(), 4'b1111);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule